// File: doc/BRIEF.md
# Look-Ahead Memory Request Queue

This block sits between the request side of a memory controller and its command scheduler. Incoming requests arrive as 64-bit beats, each with an address and a flag that marks the final beat of a transaction. The queue keeps them in arrival order and presents the oldest beat to the scheduler. Alongside that beat it reports how the targeted bank currently stands: closed, open on the requested row, or open on some other row. The scheduler can then plan precharge and activate commands before it takes the beat.

Back-pressure works two ways. The queue stops accepting beats when every entry is occupied. It also stops when it already holds the maximum number of complete transactions, even if entries are still free. Both sides use valid/ready. A beat moves on a clock edge where valid and ready are both high. While `s_ready` is low, the upstream side must hold its beat, and whatever it presents is not stored. `s_ready` comes from a register that is loaded from the occupancy counts of the next state. It therefore never promises room that the following edge takes away. `m_valid` stays high while any beat is stored. The head fields stay steady until `m_ready` takes the beat.

Top module: `lookahead_req_fifo`

## Requirements
- R1: While `rst_n` is low, `s_ready`, `m_valid`, `beat_count` and `txn_count` are all 0. `s_ready` rises at the first clock edge after reset is released.
- R2: `beat_count` equals the number of beats stored. It rises by one for each accepted beat and falls by one for each beat taken.
- R3: When `beat_count` equals DEPTH (9 by default), `s_ready` is low.
- R4: When `txn_count` equals MAX_TXN (4 by default), `s_ready` is low, whatever the number of free entries.
- R5: After every clock edge, `s_ready` is high exactly when the post-edge `beat_count` is below DEPTH and the post-edge `txn_count` is below MAX_TXN. A beat offered while `s_ready` is high is therefore always stored.
- R6: A beat offered while `s_ready` is low is not stored. It changes neither the counts nor any later head contents.
- R7: Beats leave in the order they were accepted. `m_data`, `m_addr` and `m_last` show the oldest stored beat.
- R8: `txn_count` rises when a beat with its last flag set is accepted and falls when such a beat is taken. When both happen on the same edge, it is unchanged.
- R9: The head address splits, from the least significant bit up, into COL_W column bits, BANK_W bank bits and ROW_W row bits. `m_bank_state` reads 0 when `bank_open_i[bank]` is 0. It reads 1 when that bank is open and `bank_row_i[bank*ROW_W +: ROW_W]` equals the row. It reads 2 when the bank is open on a different row.
- R10: `m_valid` is high exactly when `beat_count` is nonzero. While `m_valid` is high and `m_ready` is low, the head fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Queue accepts a beat this cycle |
| s_data | input | DATA_W | Upstream beat payload |
| s_addr | input | COL_W+BANK_W+ROW_W | Upstream beat address |
| s_last | input | 1 | Final beat of its transaction |
| m_valid | output | 1 | Head beat present |
| m_ready | input | 1 | Scheduler takes the head beat |
| m_data | output | DATA_W | Head beat payload |
| m_addr | output | COL_W+BANK_W+ROW_W | Head beat address |
| m_last | output | 1 | Head beat ends its transaction |
| m_bank_state | output | 2 | Target bank status of the head beat: 0 closed, 1 row hit, 2 row conflict |
| bank_open_i | input | NBANK | Per-bank open flag from the scheduler |
| bank_row_i | input | NBANK*ROW_W | Per-bank open row, packed by bank index |
| beat_count | output | CNT_W | Beats stored |
| txn_count | output | TXN_W | Complete transactions stored |

## Verification
The bench builds the block with DEPTH=5, MAX_TXN=2, DATA_W=16 and two bits each for column, bank and row. This small setup lets both limits be hit within a few cycles. It also lets every bank-status outcome occur across all 64 head addresses. The bench sweeps all 64 combinations of four input-valid rates, four last-beat rates and four take rates. This covers the case where the queue fills with one unfinished transaction and the case where it stops on the transaction cap with entries still free. It also drives back-to-back blocked offers and edges where a last beat enters and leaves together.

// File: rtl/lafifo_pkg.sv
package lafifo_pkg;

  typedef enum logic [1:0] {
    BANK_CLOSED   = 2'd0,
    BANK_ROW_HIT  = 2'd1,
    BANK_ROW_MISS = 2'd2
  } bank_state_e;

endpackage

// File: rtl/lafifo_store.sv
// Circular entry storage; write and read pointers wrap at DEPTH.
module lafifo_store #(
  parameter int DEPTH  = 9,
  parameter int WORD_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word
);

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [WORD_W-1:0] ent_q [DEPTH];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr == PTR_W'(i))) q <= wr_word;
    end
    assign ent_q[i] = q;
  end

  assign rd_word = ent_q[rd_ptr];

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr < PTR_W'(DEPTH)) && (rd_ptr < PTR_W'(DEPTH)));

endmodule

// File: rtl/lafifo_occupancy.sv
// Beat and complete-transaction counters plus the registered accept flag.
module lafifo_occupancy #(
  parameter int DEPTH   = 9,
  parameter int MAX_TXN = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int TXN_W  = $clog2(MAX_TXN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_last,
  input  logic             pop,
  input  logic             pop_last,
  output logic [CNT_W-1:0] beat_q,
  output logic [TXN_W-1:0] txn_q,
  output logic             accept_q
);

  logic [CNT_W-1:0] beat_nxt;
  logic [TXN_W-1:0] txn_nxt;
  logic             txn_inc, txn_dec;

  assign txn_inc = push && push_last;
  assign txn_dec = pop && pop_last;

  always_comb begin
    beat_nxt = beat_q + CNT_W'(push) - CNT_W'(pop);
    txn_nxt  = txn_q + TXN_W'(txn_inc) - TXN_W'(txn_dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q   <= '0;
      txn_q    <= '0;
      accept_q <= 1'b0;
    end else begin
      beat_q   <= beat_nxt;
      txn_q    <= txn_nxt;
      accept_q <= (beat_nxt < CNT_W'(DEPTH)) && (txn_nxt < TXN_W'(MAX_TXN));
    end
  end

  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_q == CNT_W'(DEPTH)) |-> !accept_q);

  // R4
  txn_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_q == TXN_W'(MAX_TXN)) |-> !accept_q);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (beat_q < CNT_W'(DEPTH)));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (beat_q != '0));

  // R8
  txn_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(txn_q) <= beat_q);

endmodule

// File: rtl/lafifo_bank_class.sv
// Classifies the head request against the scheduler's open-row table.
module lafifo_bank_class
  import lafifo_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic [BANK_W-1:0]      bank_sel,
  input  logic [ROW_W-1:0]       row_sel,
  input  logic [NBANK-1:0]       bank_open,
  input  logic [NBANK*ROW_W-1:0] bank_row,
  output bank_state_e            state
);

  logic [NBANK-1:0] row_match;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign row_match[b] = (bank_row[b*ROW_W +: ROW_W] == row_sel);
  end

  always_comb begin
    if (!bank_open[bank_sel])     state = BANK_CLOSED;
    else if (row_match[bank_sel]) state = BANK_ROW_HIT;
    else                          state = BANK_ROW_MISS;
  end

endmodule

// File: rtl/lookahead_req_fifo.sv
module lookahead_req_fifo
  import lafifo_pkg::*;
#(
  parameter int DEPTH   = 9,
  parameter int MAX_TXN = 4,
  parameter int DATA_W  = 64,
  parameter int COL_W   = 10,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  localparam int ADDR_W = COL_W + BANK_W + ROW_W,
  localparam int NBANK  = 1 << BANK_W,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int TXN_W  = $clog2(MAX_TXN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [DATA_W-1:0]      s_data,
  input  logic [ADDR_W-1:0]      s_addr,
  input  logic                   s_last,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [DATA_W-1:0]      m_data,
  output logic [ADDR_W-1:0]      m_addr,
  output logic                   m_last,
  output logic [1:0]             m_bank_state,
  input  logic [NBANK-1:0]       bank_open_i,
  input  logic [NBANK*ROW_W-1:0] bank_row_i,
  output logic [CNT_W-1:0]       beat_count,
  output logic [TXN_W-1:0]       txn_count
);

  localparam int WORD_W = 1 + ADDR_W + DATA_W;

  logic              push, pop;
  logic [WORD_W-1:0] wr_word, rd_word;
  bank_state_e       head_state;

  assign push    = s_valid && s_ready;
  assign pop     = m_valid && m_ready;
  assign wr_word = {s_last, s_addr, s_data};
  assign {m_last, m_addr, m_data} = rd_word;
  assign m_valid = (beat_count != '0);

  lafifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push),
    .wr_word (wr_word),
    .rd_en   (pop),
    .rd_word (rd_word)
  );

  lafifo_occupancy #(.DEPTH(DEPTH), .MAX_TXN(MAX_TXN)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_last (s_last),
    .pop       (pop),
    .pop_last  (m_last),
    .beat_q    (beat_count),
    .txn_q     (txn_count),
    .accept_q  (s_ready)
  );

  lafifo_bank_class #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_class (
    .bank_sel  (m_addr[COL_W +: BANK_W]),
    .row_sel   (m_addr[COL_W+BANK_W +: ROW_W]),
    .bank_open (bank_open_i),
    .bank_row  (bank_row_i),
    .state     (head_state)
  );

  assign m_bank_state = head_state;

  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) &&
                               $stable(m_addr) && $stable(m_last)));

  // R6
  blocked_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready && !pop) |=> $stable(beat_count) && $stable(txn_count));

  // R9
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_bank_state != 2'd3);

endmodule

// File: tb/lookahead_req_fifo_tb.sv
module lookahead_req_fifo_tb;

  localparam int DEPTH   = 5;
  localparam int MAX_TXN = 2;
  localparam int DATA_W  = 16;
  localparam int COL_W   = 2;
  localparam int BANK_W  = 2;
  localparam int ROW_W   = 2;
  localparam int ADDR_W  = COL_W + BANK_W + ROW_W;
  localparam int NBANK   = 1 << BANK_W;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int TXN_W   = $clog2(MAX_TXN + 1);
  localparam int ENT_W   = 1 + ADDR_W + DATA_W;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   s_valid = 1'b0;
  logic                   s_ready;
  logic [DATA_W-1:0]      s_data = '0;
  logic [ADDR_W-1:0]      s_addr = '0;
  logic                   s_last = 1'b0;
  logic                   m_valid;
  logic                   m_ready = 1'b0;
  logic [DATA_W-1:0]      m_data;
  logic [ADDR_W-1:0]      m_addr;
  logic                   m_last;
  logic [1:0]             m_bank_state;
  logic [NBANK-1:0]       bank_open_i = '0;
  logic [NBANK*ROW_W-1:0] bank_row_i = '0;
  logic [CNT_W-1:0]       beat_count;
  logic [TXN_W-1:0]       txn_count;

  always #4 clk = ~clk;

  lookahead_req_fifo #(
    .DEPTH(DEPTH), .MAX_TXN(MAX_TXN), .DATA_W(DATA_W),
    .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_addr(s_addr), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_addr(m_addr), .m_last(m_last), .m_bank_state(m_bank_state),
    .bank_open_i(bank_open_i), .bank_row_i(bank_row_i),
    .beat_count(beat_count), .txn_count(txn_count)
  );

  int unsigned errs = 0;
  int unsigned checks = 0;
  int unsigned rnd = 32'h1234_5678;
  bit          done = 1'b0;

  logic [ENT_W-1:0] mq [$];
  int               txn_m = 0;
  bit               rdy_m = 1'b0;
  bit               blocked_prev = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned roll();
    rnd = rnd * 32'd1664525 + 32'd1013904223;
    return (rnd >> 16) & 32'hFFFF;
  endfunction

  function automatic int exp_state(input logic [ADDR_W-1:0] a);
    int bank = (a >> COL_W) % NBANK;
    int row  = (a >> (COL_W + BANK_W)) % (1 << ROW_W);
    int tab  = (bank_row_i >> (bank * ROW_W)) % (1 << ROW_W);
    if (!bank_open_i[bank]) return 0;
    return (row == tab) ? 1 : 2;
  endfunction

  task automatic compare_all();
    string rtag;
    if (!rdy_m && mq.size() == DEPTH) rtag = "R3";
    else if (!rdy_m && txn_m == MAX_TXN) rtag = "R4";
    else rtag = "R5";
    chk(rtag, int'(s_ready), int'(rdy_m));
    chk(blocked_prev ? "R6" : "R2", int'(beat_count), mq.size());
    chk("R8", int'(txn_count), txn_m);
    chk("R10", int'(m_valid), int'(mq.size() != 0));
    if (mq.size() != 0) begin
      chk("R7", int'(m_data), int'(mq[0][DATA_W-1:0]));
      chk("R7", int'(m_addr), int'(mq[0][DATA_W +: ADDR_W]));
      chk("R7", int'(m_last), int'(mq[0][ENT_W-1]));
      chk("R9", int'(m_bank_state), exp_state(mq[0][DATA_W +: ADDR_W]));
    end
  endtask

  task automatic advance_model();
    bit push_m = s_valid && rdy_m;
    bit pop_m  = m_ready && (mq.size() != 0);
    blocked_prev = s_valid && !rdy_m;
    if (pop_m) begin
      logic [ENT_W-1:0] h = mq.pop_front();
      if (h[ENT_W-1]) txn_m--;
    end
    if (push_m) begin
      mq.push_back({s_last, s_addr, s_data});
      if (s_last) txn_m++;
    end
    rdy_m = (mq.size() < DEPTH) && (txn_m < MAX_TXN);
  endtask

  initial begin
    // R1: reset state, with an offered beat that must be ignored
    s_valid = 1'b1;
    s_data  = 16'hBEEF;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk("R1", int'(s_ready), 0);
      chk("R1", int'(m_valid), 0);
      chk("R1", int'(beat_count), 0);
      chk("R1", int'(txn_count), 0);
    end
    s_valid = 1'b0;
    rst_n   = 1'b1;
    @(posedge clk);
    advance_model();
    @(negedge clk);
    #1;
    chk("R1", int'(s_ready), 1);

    for (int vp = 0; vp < 4; vp++) begin
      for (int lp = 0; lp < 4; lp++) begin
        for (int rp = 0; rp < 4; rp++) begin
          for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            s_valid     = (roll() % 4) <= vp;
            s_last      = (roll() % 4) < lp;
            m_ready     = (roll() % 4) < rp;
            s_data      = DATA_W'(roll());
            s_addr      = ADDR_W'(roll());
            bank_open_i = NBANK'(roll());
            bank_row_i  = (NBANK*ROW_W)'(roll());
            #1;
            compare_all();
            @(posedge clk);
            advance_model();
          end
        end
      end
    end

    // drain and confirm the queue empties cleanly
    @(negedge clk);
    s_valid = 1'b0;
    m_ready = 1'b1;
    repeat (DEPTH + 2) begin
      #1;
      compare_all();
      @(posedge clk);
      advance_model();
      @(negedge clk);
    end
    #1;
    compare_all();
    chk("R2", int'(beat_count), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule